// File: doc/BRIEF.md
# Initiator Phase-Checked Transfer Sequencer

This block runs one initiator-side byte move over a REQ/ACK handshake bus. An instruction arrives as a start pulse together with a 3-bit expected bus phase, a byte count and a start address. The block then waits for a REQ that has not yet been answered. It latches the bus phase lines at the moment REQ rises and compares that latched value with the expected phase.

When the two phases differ, the block raises a one-cycle phase-mismatch interrupt and returns to idle. It moves no data and drives no ACK. When they agree, the block runs one memory access and one REQ/ACK handshake per byte. The I/O line gives the direction. Each byte advances the address by one and lowers the remaining count by one. When the count reaches zero, a one-cycle done pulse marks completion.

Two message phases need special handling at their final byte. In message-out, ATN is released in the same cycle that ACK rises for the final byte. In message-in, ACK is left asserted after the final byte until an explicit clear command arrives while the block is idle.

Top module: `ini_xfer_seq`

## Requirements
- R1: While reset is held, bus_ack, bus_atn, bus_oe, busy, done, phase_irq and mem_req are all 0.
- R2: After start, the block stays busy and makes no memory access and no ACK until REQ is high with ACK low. The phase {bus_msg, bus_cd, bus_io} is captured on the clock edge that first sees REQ high, and later changes of those lines while REQ stays high are not used.
- R3: The phase code is {MSG, C/D, I/O} with MSG as bit 2: 000 data out, 001 data in, 010 command, 011 status, 100/101 reserved, 110 message out, 111 message in. If the captured code differs from ins_phase, phase_irq pulses for exactly one cycle. In that case done stays low, no ACK and no memory access occur, and busy returns to 0.
- R4: On a phase match with count N>0, exactly N memory accesses occur at addresses ins_addr, ins_addr+1, … ins_addr+N-1, one per handshake. done then pulses once for one cycle after the final REQ is released, and busy returns to 0.
- R5: On a phase match with count 0, done pulses without any memory access or ACK, even while REQ stays high.
- R6: ACK rises only in the cycle after a granted memory access. It stays high while REQ is high, and falls two clock edges after REQ goes low, except in the message-in case of R9.
- R7: With I/O = 0, mem_we is 0 and bus_dout carries the byte read from memory, with bus_oe = 1 while ACK is high. With I/O = 1, mem_we is 1, bus_oe stays 0 and mem_wdata is the bus_din value present with that byte's REQ.
- R8: A pulse on atn_set raises bus_atn. In phase 110, bus_atn stays high across the ACK of every byte but the last, and falls in the same cycle that ACK rises for the final byte.
- R9: In phase 111, ACK stays high after the final REQ is released and after done, until clr_ack is pulsed while idle. clr_ack has no effect while busy. A start and a clr_ack in the same idle cycle both take effect.
- R10: A start pulse while busy is ignored, and the current move keeps its count and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a move with the instruction fields below (honoured only when idle) |
| ins_phase | input | 3 | Expected bus phase {MSG, C/D, I/O} |
| ins_count | input | CNT_W | Number of bytes to move |
| ins_addr | input | ADDR_W | First memory address |
| atn_set | input | 1 | Pulse that raises ATN |
| clr_ack | input | 1 | Command that releases a held ACK (idle only) |
| bus_req | input | 1 | REQ from the bus target |
| bus_msg | input | 1 | MSG phase line |
| bus_cd | input | 1 | C/D phase line |
| bus_io | input | 1 | I/O phase line |
| bus_din | input | DATA_W | Inbound bus data |
| bus_ack | output | 1 | ACK to the bus target |
| bus_atn | output | 1 | ATN to the bus target |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_dout | output | DATA_W | Outbound bus data |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Byte to write |
| mem_rdata | input | DATA_W | Byte read, valid with mem_gnt |
| mem_gnt | input | 1 | Memory grant |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| phase_irq | output | 1 | One-cycle phase-mismatch interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the release of a held message-in ACK and the start of the next move. The bench ends a message-in move with ACK still held, then pulses clr_ack and start together in one idle cycle. It judges the result by ACK dropping on the next edge while busy rises, and by the following data-out byte completing normally.

The second pair is the final-byte ACK rise and the ATN release in message-out. The bench records ATN at every ACK it observes and expects it low only on the last one.

The sweep covers all 64 pairs of expected and presented phase, and a count sweep covers zero, single-byte and multi-byte moves, including an address carry.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEM  = 2'd2,
        ST_ACK  = 2'd3
    } ixs_state_e;

    localparam logic [2:0] PH_MSG_OUT = 3'b110;
    localparam logic [2:0] PH_MSG_IN  = 3'b111;

endpackage

// File: rtl/ixs_req_latch.sv
module ixs_req_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic       bus_msg,
    input  logic       bus_cd,
    input  logic       bus_io,
    output logic       req_q,
    output logic [2:0] phase_q
);

    typedef struct packed {
        logic       req;
        logic [2:0] phase;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d     = lat_q;
        lat_d.req = bus_req;
        if (bus_req && !lat_q.req) begin
            lat_d.phase = {bus_msg, bus_cd, bus_io};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign req_q   = lat_q.req;
    assign phase_q = lat_q.phase;

    // R2: the captured phase does not follow the lines while REQ stays high
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && bus_req) |=> $stable(phase_q));

endmodule

// File: rtl/ixs_counter.sv
module ixs_counter #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              cnt_last,
    output logic              cnt_zero
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.cnt  = cnt_i;
            ctr_d.addr = addr_i;
        end else if (step) begin
            ctr_d.cnt  = ctr_q.cnt - CNT_ONE;
            ctr_d.addr = ctr_q.addr + ADDR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_q    = ctr_q.cnt;
    assign addr_q   = ctr_q.addr;
    assign cnt_last = (ctr_q.cnt == CNT_ONE);
    assign cnt_zero = (ctr_q.cnt == '0);

    // R4: a byte is never taken from an exhausted count
    p_step_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);

    // R4: each byte moves the count down and the address up by one
    p_step_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == $past(cnt_q) - CNT_ONE) &&
                            (addr_q == $past(addr_q) + ADDR_ONE));

endmodule

// File: rtl/ini_xfer_seq.sv
module ini_xfer_seq
    import ixs_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        ins_phase,
    input  logic [CNT_W-1:0]  ins_count,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              atn_set,
    input  logic              clr_ack,
    input  logic              bus_req,
    input  logic              bus_msg,
    input  logic              bus_cd,
    input  logic              bus_io,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_ack,
    output logic              bus_atn,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              busy,
    output logic              done,
    output logic              phase_irq
);

    typedef struct packed {
        ixs_state_e        state;
        logic [2:0]        ins_ph;
        logic              checked;
        logic              ack;
        logic              atn;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              irq;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              req_q;
    logic [2:0]        phase_q;
    logic              ctr_load;
    logic              ctr_step;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cnt_last;
    logic              cnt_zero;

    ixs_req_latch u_req_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_req (bus_req),
        .bus_msg (bus_msg),
        .bus_cd  (bus_cd),
        .bus_io  (bus_io),
        .req_q   (req_q),
        .phase_q (phase_q)
    );

    ixs_counter #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .step     (ctr_step),
        .cnt_i    (ins_count),
        .addr_i   (ins_addr),
        .cnt_q    (cnt_q),
        .addr_q   (addr_q),
        .cnt_last (cnt_last),
        .cnt_zero (cnt_zero)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.irq  = 1'b0;
        ctr_load   = 1'b0;
        ctr_step   = 1'b0;

        if (atn_set) begin
            seq_d.atn = 1'b1;
        end

        unique case (seq_q.state)
            ST_IDLE: begin
                if (clr_ack) begin
                    seq_d.ack = 1'b0;
                end
                if (start) begin
                    ctr_load      = 1'b1;
                    seq_d.ins_ph  = ins_phase;
                    seq_d.checked = 1'b0;
                    seq_d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (req_q && !seq_q.ack) begin
                    if (!seq_q.checked && (phase_q != seq_q.ins_ph)) begin
                        seq_d.irq   = 1'b1;
                        seq_d.state = ST_IDLE;
                    end else if (cnt_zero) begin
                        seq_d.done  = 1'b1;
                        seq_d.state = ST_IDLE;
                    end else begin
                        seq_d.checked = 1'b1;
                        seq_d.data    = bus_din;
                        seq_d.state   = ST_MEM;
                    end
                end
            end
            ST_MEM: begin
                if (mem_gnt) begin
                    ctr_step = 1'b1;
                    if (!seq_q.ins_ph[0]) begin
                        seq_d.data = mem_rdata;
                    end
                    seq_d.ack = 1'b1;
                    if (cnt_last && (seq_q.ins_ph == PH_MSG_OUT)) begin
                        seq_d.atn = 1'b0;
                    end
                    seq_d.state = ST_ACK;
                end
            end
            ST_ACK: begin
                if (!req_q) begin
                    if (!(cnt_zero && (seq_q.ins_ph == PH_MSG_IN))) begin
                        seq_d.ack = 1'b0;
                    end
                    if (cnt_zero) begin
                        seq_d.done  = 1'b1;
                        seq_d.state = ST_IDLE;
                    end else begin
                        seq_d.state = ST_WAIT;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_ack   = seq_q.ack;
    assign bus_atn   = seq_q.atn;
    assign bus_oe    = (seq_q.state == ST_ACK) && !seq_q.ins_ph[0];
    assign bus_dout  = seq_q.data;
    assign mem_req   = (seq_q.state == ST_MEM);
    assign mem_we    = seq_q.ins_ph[0];
    assign mem_addr  = addr_q;
    assign mem_wdata = seq_q.data;
    assign busy      = (seq_q.state != ST_IDLE);
    assign done      = seq_q.done;
    assign phase_irq = seq_q.irq;

    // R6: ACK only follows a granted memory access
    p_ack_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(mem_req && mem_gnt));

    // R6: ACK is not dropped while REQ is still registered high
    p_ack_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && req_q) |=> bus_ack);

    // R3: a mismatch interrupt never comes with a completion, ACK or access
    p_irq_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_irq |-> (!done && !bus_ack && !mem_req));

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: data is driven onto the bus only for memory reads
    p_oe_outbound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_ack && !mem_we));

    // R8: ATN falls only together with the final ACK rise
    p_atn_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_atn) |-> ($rose(bus_ack) && cnt_zero));

    // R9: a held ACK survives idle cycles without a clear command
    p_ack_held_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_ack && !clr_ack) |=> bus_ack);

endmodule

// File: tb/ini_xfer_seq_bench.sv
`timescale 1ns/1ps
module ini_xfer_seq_bench;

    localparam int CW = 24;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    ins_phase = '0;
    logic [CW-1:0] ins_count = '0;
    logic [AW-1:0] ins_addr = '0;
    logic          atn_set = 1'b0;
    logic          clr_ack = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_msg = 1'b0;
    logic          bus_cd = 1'b0;
    logic          bus_io = 1'b0;
    logic [7:0]    bus_din = '0;
    logic          bus_ack, bus_atn, bus_oe;
    logic [7:0]    bus_dout;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          mem_gnt = 1'b0;
    logic          busy, done, phase_irq;

    always #2.5 clk = ~clk;

    ini_xfer_seq u_ini_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ins_phase(ins_phase),
        .ins_count(ins_count), .ins_addr(ins_addr), .atn_set(atn_set),
        .clr_ack(clr_ack), .bus_req(bus_req), .bus_msg(bus_msg),
        .bus_cd(bus_cd), .bus_io(bus_io), .bus_din(bus_din),
        .bus_ack(bus_ack), .bus_atn(bus_atn), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .busy(busy), .done(done), .phase_irq(phase_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int done_n = 0, irq_n = 0, ackrise_n = 0, acc_n = 0;
    logic ack_prev = 1'b0;
    logic [AW-1:0] acc_addr [16];
    logic          acc_we   [16];
    logic [7:0]    acc_wd   [16];
    logic [7:0]    seen_dout [16];
    logic          seen_oe   [16];
    logic          seen_atn  [16];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (done) done_n++;
        if (phase_irq) irq_n++;
        if (bus_ack && !ack_prev) ackrise_n++;
        ack_prev = bus_ack;
    end

    initial begin
        forever begin
            @(negedge clk);
            if (mem_gnt) begin
                mem_gnt = 1'b0;
            end else if (mem_req) begin
                if (acc_n < 16) begin
                    acc_addr[acc_n] = mem_addr;
                    acc_we[acc_n]   = mem_we;
                    acc_wd[acc_n]   = mem_wdata;
                end
                acc_n++;
                mem_rdata = mem_addr[7:0] ^ 8'hA5;
                mem_gnt   = 1'b1;
            end
        end
    end

    function automatic logic [7:0] din_of(input int i, input logic [2:0] ph);
        return 8'h40 + 8'(i * 8) + {5'd0, ph};
    endfunction

    task automatic clear_stats();
        @(posedge clk);
        done_n = 0; irq_n = 0; ackrise_n = 0; acc_n = 0;
    endtask

    task automatic issue(input logic [2:0] ph, input int cnt,
                         input logic [AW-1:0] base, input bit with_clr);
        @(negedge clk);
        start = 1'b1; ins_phase = ph; ins_count = CW'(cnt);
        ins_addr = base; clr_ack = with_clr;
        @(negedge clk);
        start = 1'b0; clr_ack = 1'b0;
    endtask

    task automatic pulse_atn();
        @(negedge clk);
        atn_set = 1'b1;
        @(negedge clk);
        atn_set = 1'b0;
    endtask

    task automatic target_byte(input logic [2:0] ph, input logic [7:0] din,
                               input bit hold, input int idx);
        int t;
        @(negedge clk);
        {bus_msg, bus_cd, bus_io} = ph;
        bus_din = din;
        bus_req = 1'b1;
        t = 0;
        while (!bus_ack && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(bus_ack === 1'b1, "R6", "ACK answers REQ", bus_ack, 1);
        seen_dout[idx] = bus_dout;
        seen_oe[idx]   = bus_oe;
        seen_atn[idx]  = bus_atn;
        @(negedge clk);
        chk(bus_ack === 1'b1, "R6", "ACK held while REQ high", bus_ack, 1);
        bus_req = 1'b0;
        if (!hold) begin
            @(negedge clk);
            chk(bus_ack === 1'b1, "R6", "ACK one edge after REQ low", bus_ack, 1);
            @(negedge clk);
            chk(bus_ack === 1'b0, "R6", "ACK released after REQ low", bus_ack, 0);
        end
    endtask

    task automatic run_move(input logic [2:0] ip, input logic [2:0] bp,
                            input int cnt, input logic [AW-1:0] base,
                            input bit clear_hold);
        bit m;
        m = (ip == bp);
        if (ip == 3'b110) pulse_atn();
        clear_stats();
        issue(ip, cnt, base, 1'b0);
        if (m && cnt > 0) begin
            for (int i = 0; i < cnt; i++) begin
                target_byte(bp, din_of(i, ip), (ip == 3'b111) && (i == cnt - 1), i);
            end
        end else begin
            @(negedge clk);
            {bus_msg, bus_cd, bus_io} = bp;
            bus_req = 1'b1;
            repeat (6) @(negedge clk);
            bus_req = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(irq_n == (m ? 0 : 1), "R3", "mismatch interrupt count", irq_n, m ? 0 : 1);
        chk(done_n == (m ? 1 : 0), m ? "R4" : "R3", "done count", done_n, m ? 1 : 0);
        chk(acc_n == (m ? cnt : 0), m ? "R4" : "R3", "memory access count", acc_n, m ? cnt : 0);
        chk(busy === 1'b0, "R4", "busy after move", busy, 0);
        if (!m) chk(ackrise_n == 0, "R3", "no ACK on mismatch", ackrise_n, 0);
        if (m && cnt == 0) chk(ackrise_n == 0, "R5", "no ACK on zero count", ackrise_n, 0);
        if (m) begin
            for (int i = 0; i < cnt && i < 16 && i < acc_n; i++) begin
                chk(acc_addr[i] == base + AW'(i), "R4", "access address", acc_addr[i], base + AW'(i));
                chk(acc_we[i] == ip[0], "R7", "access direction", acc_we[i], ip[0]);
                if (ip[0]) begin
                    chk(acc_wd[i] == din_of(i, ip), "R7", "inbound byte", acc_wd[i], din_of(i, ip));
                    chk(seen_oe[i] == 1'b0, "R7", "no drive inbound", seen_oe[i], 0);
                end else begin
                    chk(seen_dout[i] == ((base[7:0] + 8'(i)) ^ 8'hA5), "R7", "outbound byte",
                        seen_dout[i], (base[7:0] + 8'(i)) ^ 8'hA5);
                    chk(seen_oe[i] == 1'b1, "R7", "drive outbound", seen_oe[i], 1);
                end
                if (ip == 3'b110) begin
                    chk(seen_atn[i] == (i != cnt - 1), "R8", "ATN at ACK", seen_atn[i], i != cnt - 1);
                end
            end
        end
        if (m && ip == 3'b111 && cnt > 0) begin
            chk(bus_ack === 1'b1, "R9", "ACK held after message-in", bus_ack, 1);
            if (clear_hold) begin
                @(negedge clk);
                clr_ack = 1'b1;
                @(negedge clk);
                clr_ack = 1'b0;
                chk(bus_ack === 1'b0, "R9", "ACK cleared by command", bus_ack, 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk(bus_ack === 1'b0, "R1", "reset ack", bus_ack, 0);
        chk(bus_atn === 1'b0, "R1", "reset atn", bus_atn, 0);
        chk(bus_oe === 1'b0, "R1", "reset oe", bus_oe, 0);
        chk(busy === 1'b0, "R1", "reset busy", busy, 0);
        chk(done === 1'b0, "R1", "reset done", done, 0);
        chk(phase_irq === 1'b0, "R1", "reset irq", phase_irq, 0);
        chk(mem_req === 1'b0, "R1", "reset mem_req", mem_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: no action before REQ; phase is taken at the REQ rise
        clear_stats();
        issue(3'b001, 1, 32'h0000_2000, 1'b0);
        {bus_msg, bus_cd, bus_io} = 3'b001;
        repeat (6) begin
            @(negedge clk);
            chk(busy === 1'b1 && mem_req === 1'b0 && bus_ack === 1'b0, "R2",
                "idle while REQ low", {busy, mem_req, bus_ack}, 3'b100);
        end
        bus_din = 8'h77;
        bus_req = 1'b1;
        @(negedge clk);
        {bus_msg, bus_cd, bus_io} = 3'b110;
        t = 0;
        while (!bus_ack && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(bus_ack === 1'b1, "R2", "latched phase used", bus_ack, 1);
        // R9: clear command ignored while busy
        clr_ack = 1'b1;
        @(negedge clk);
        clr_ack = 1'b0;
        chk(bus_ack === 1'b1, "R9", "clr_ack ignored while busy", bus_ack, 1);
        bus_req = 1'b0;
        repeat (5) @(negedge clk);
        chk(irq_n == 0 && done_n == 1, "R2", "latched-phase move done", {irq_n[3:0], done_n[3:0]}, 8'h01);
        chk(acc_n == 1 && acc_wd[0] == 8'h77, "R7", "latched-phase byte", acc_wd[0], 8'h77);

        // R10: start while busy is ignored
        clear_stats();
        issue(3'b000, 2, 32'h0000_3000, 1'b0);
        issue(3'b001, 5, 32'h0000_9000, 1'b0);
        for (int i = 0; i < 2; i++) target_byte(3'b000, 8'h00, 1'b0, i);
        repeat (4) @(negedge clk);
        chk(acc_n == 2, "R10", "accesses keep first count", acc_n, 2);
        chk(acc_addr[1] == 32'h0000_3001, "R10", "address keeps first base", acc_addr[1], 32'h0000_3001);
        chk(done_n == 1 && busy === 1'b0, "R10", "first move completes", done_n, 1);

        // full phase sweep: expected vs presented
        for (int ip = 0; ip < 8; ip++) begin
            for (int bp = 0; bp < 8; bp++) begin
                run_move(3'(ip), 3'(bp), (ip + bp) % 3, 32'h1000_0000 + AW'(ip * 16 + bp), 1'b1);
            end
        end

        // count sweep with an address carry
        for (int c = 0; c < 7; c++) begin
            run_move(3'b000, 3'b000, c, 32'h0000_01FD, 1'b1);
            run_move(3'b001, 3'b001, c, 32'h0000_02FE, 1'b1);
            run_move(3'b110, 3'b110, c, 32'h0000_0400, 1'b1);
            run_move(3'b111, 3'b111, c, 32'h0000_0500, 1'b1);
        end

        // R9: clear command and start in the same idle cycle
        run_move(3'b111, 3'b111, 1, 32'h0000_0600, 1'b0);
        clear_stats();
        issue(3'b000, 1, 32'h0000_0700, 1'b1);
        chk(bus_ack === 1'b0, "R9", "ACK cleared with start", bus_ack, 0);
        chk(busy === 1'b1, "R9", "start taken with clear", busy, 1);
        target_byte(3'b000, 8'h00, 1'b0, 0);
        repeat (4) @(negedge clk);
        chk(done_n == 1 && acc_n == 1, "R9", "move after merged clear", {done_n[3:0], acc_n[3:0]}, 8'h11);
        chk(seen_dout[0] == (8'h00 ^ 8'hA5), "R9", "byte after merged clear", seen_dout[0], 8'hA5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule